// File: doc/BRIEF.md
# Boot mode capture and multi-function port configurator

This block records the operating mode of the chip from mode-select levels present while reset is held. It then drives the pin controls of one 8-bit multi-function port: per-pin output enable, pull-up enable and alternate-function select. After reset, a small register port lets software set three alternate-function enables, a general-purpose direction mask and a bus-cycle stretch bit. The enables only take effect, and only hold a written value, when the captured mode has an external bus. In single-chip configurations they stay at zero whatever software writes.

Two port pins double as mode-select inputs. These are pins 6 and 5. While reset is active, and until the mode has been captured, the block leaves them floating: no output drive and no pull-up. Pins 1 and 0 are fixed inputs with pull-ups. They feed the maskable and non-maskable interrupt requests. Each request is passed on only when the processor's enable for it is set, and never before the mode has been captured.

Top module: `boot_port_cfg`

## Requirements
- R1: Mode capture happens on the first rising clock edge after reset is released. At that edge the block samples `mode_ab_i` (bit 1 is the level on pin 6, bit 0 the level on pin 5), and the sampled value is kept until the next reset. A value of 00 selects single-chip operation, and any other value selects an expanded configuration. Changes on `mode_ab_i` after capture have no effect.
- R2: Before capture (reset active, or no edge yet since release), every pin has output enable 0 and function select 0. Pins 6 and 5 also have pull-up 0. All other pins have pull-up 1.
- R3: Pins 1 and 0 always have output enable 0, function select 0 and pull-up 1. Writes to direction bits 1:0 are ignored, and those bits read back 0.
- R4: `irq_req_o` is 1 exactly when the mode has been captured, `irq_en_i` is 1 and `irq_pin_n_i` is 0. `xirq_req_o` follows the same rule with `xirq_en_i` and `xirq_pin_n_i`.
- R5: In single-chip mode, a write to the control register (address 0) leaves it at zero. The register reads back 0 and no pin has function select 1.
- R6: In an expanded mode, control bit 0 hands pins 7, 6 and 5 to the pipe-status function. Control bit 1 hands pin 3 to the low-byte strobe, and control bit 2 hands pin 2 to read/write. A pin handed over has function select 1 and output enable 1. Control bits 2:0 read back as written.
- R7: The stretch bit (address 1, bit 0) comes out of reset as the level of `mode_c_i` at the capture edge, where 1 means a user mode. After that, writes set it in every mode, and it reads back as written.
- R8: On pins 7..2, output enable equals the alternate-function select OR'ed with the direction bit (address 2). The pull-up is the inverse of the output enable.
- R9: All three control bits read 0 after reset in every mode, and no pin is handed to an alternate function.
- R10: Address 3 reads 0. Reads return the upper bits of addresses 0 and 1 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_c_i | input | 1 | Dedicated mode pin, 1 = user mode |
| mode_ab_i | input | 2 | Levels on pins 6 and 5 (mode select during reset) |
| irq_pin_n_i | input | 1 | Pin 1 level, active-low maskable request |
| xirq_pin_n_i | input | 1 | Pin 0 level, active-low non-maskable request |
| irq_en_i | input | 1 | Processor enable for the maskable request |
| xirq_en_i | input | 1 | Processor enable for the non-maskable request |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for reads and writes |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for `addr_i` |
| pin_oe_o | output | 8 | Per-pin output enable |
| pin_pu_o | output | 8 | Per-pin pull-up enable |
| pin_fsel_o | output | 8 | Per-pin alternate-function select |
| irq_req_o | output | 1 | Qualified maskable request |
| xirq_req_o | output | 1 | Qualified non-maskable request |

## Verification
If the wrong mode is latched, the block shows it on the cycle after the first control write. That write then sticks or does not, which is visible both in the read-back and in `pin_fsel_o`. A stretch bit preset wrongly is visible on the first read of address 1 after reset. A corrupted direction or control flop shows up at once on `pin_oe_o` and `pin_pu_o`, because those are pure combinational functions of the held state. A capture flag that sets too early or too late shows in the pull-ups of pins 6 and 5 and in the interrupt outputs, in the first cycle after release.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam int PORT_W = 8;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  typedef logic [1:0] mode_t;
  localparam mode_t MODE_SINGLE = 2'b00;

  typedef struct packed {
    logic rw_en;
    logic lstrb_en;
    logic pipe_en;
  } altctl_t;

  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] A_TIMING = 2'd1;
  localparam logic [ADDR_W-1:0] A_DIR    = 2'd2;

  localparam int PIN_XIRQ  = 0;
  localparam int PIN_IRQ   = 1;
  localparam int PIN_RW    = 2;
  localparam int PIN_LSTRB = 3;
  localparam int PIN_MSEL0 = 5;
  localparam int PIN_MSEL1 = 6;
  localparam logic [PORT_W-1:0] PIPE_MASK  = 8'hE0;
  localparam logic [PORT_W-1:0] INPUT_MASK = 8'h03;

  function automatic logic is_single(mode_t m);
    return m == MODE_SINGLE;
  endfunction
endpackage

// File: rtl/bpc_mode_latch.sv
module bpc_mode_latch
  import bpc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t mode_ab_i,
  output mode_t mode_o,
  output logic  run_o
);
  logic  run_q, run_d;
  mode_t mode_q, mode_d;

  always_comb begin
    run_d  = run_q;
    mode_d = mode_q;
    if (!run_q) begin
      run_d  = 1'b1;
      mode_d = mode_ab_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= MODE_SINGLE;
    end else begin
      run_q  <= run_d;
      mode_q <= mode_d;
    end
  end

  assign mode_o = mode_q;
  assign run_o  = run_q;
endmodule

// File: rtl/bpc_regs.sv
module bpc_regs
  import bpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  mode_t             mode_i,
  input  logic              boot_user_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output altctl_t           ctl_o,
  output logic [PORT_W-1:0] dir_o
);
  localparam int CTL_W = $bits(altctl_t);

  altctl_t           ctl_q, ctl_d;
  logic              stretch_q, stretch_d;
  logic [PORT_W-1:0] dir_q, dir_d;
  logic              allow_alt;
  logic              wr_ok;

  assign allow_alt = run_i && !is_single(mode_i);
  assign wr_ok     = wr_en_i && run_i;

  always_comb begin
    ctl_d     = ctl_q;
    stretch_d = stretch_q;
    dir_d     = dir_q;
    if (!run_i) begin
      stretch_d = boot_user_i;
    end else if (wr_ok) begin
      case (addr_i)
        A_CTRL:   if (allow_alt) ctl_d = altctl_t'(wr_data_i[CTL_W-1:0]);
        A_TIMING: stretch_d = wr_data_i[0];
        A_DIR:    dir_d = wr_data_i[PORT_W-1:0] & ~INPUT_MASK;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      stretch_q <= 1'b1;
      dir_q     <= '0;
    end else begin
      ctl_q     <= ctl_d;
      stretch_q <= stretch_d;
      dir_q     <= dir_d;
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      A_CTRL:   rd_data_o[CTL_W-1:0] = allow_alt ? ctl_q : '0;
      A_TIMING: rd_data_o[0] = stretch_q;
      A_DIR:    rd_data_o[PORT_W-1:0] = dir_q;
      default:  ;
    endcase
  end

  assign ctl_o = allow_alt ? ctl_q : '0;
  assign dir_o = dir_q;
endmodule

// File: rtl/bpc_pin_ctrl.sv
module bpc_pin_ctrl
  import bpc_pkg::*;
(
  input  logic              run_i,
  input  altctl_t           ctl_i,
  input  logic [PORT_W-1:0] dir_i,
  input  logic              irq_pin_n_i,
  input  logic              xirq_pin_n_i,
  input  logic              irq_en_i,
  input  logic              xirq_en_i,
  output logic [PORT_W-1:0] oe_o,
  output logic [PORT_W-1:0] pu_o,
  output logic [PORT_W-1:0] fsel_o,
  output logic              irq_req_o,
  output logic              xirq_req_o
);
  logic [PORT_W-1:0] alt_vec;

  always_comb begin
    alt_vec = {PORT_W{ctl_i.pipe_en}} & PIPE_MASK;
    alt_vec[PIN_LSTRB] = ctl_i.lstrb_en;
    alt_vec[PIN_RW]    = ctl_i.rw_en;
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    if (i == PIN_IRQ || i == PIN_XIRQ) begin : g_in
      assign oe_o[i]   = 1'b0;
      assign pu_o[i]   = 1'b1;
      assign fsel_o[i] = 1'b0;
    end else if (i == PIN_MSEL0 || i == PIN_MSEL1) begin : g_msel
      logic drive;
      assign drive     = alt_vec[i] | dir_i[i];
      assign oe_o[i]   = run_i & drive;
      assign pu_o[i]   = run_i & ~drive;
      assign fsel_o[i] = run_i & alt_vec[i];
    end else begin : g_io
      logic drive;
      assign drive     = alt_vec[i] | dir_i[i];
      assign oe_o[i]   = drive;
      assign pu_o[i]   = ~drive;
      assign fsel_o[i] = alt_vec[i];
    end
  end

  assign irq_req_o  = run_i & irq_en_i  & ~irq_pin_n_i;
  assign xirq_req_o = run_i & xirq_en_i & ~xirq_pin_n_i;
endmodule

// File: rtl/boot_port_cfg.sv
module boot_port_cfg
  import bpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_c_i,
  input  logic [1:0]        mode_ab_i,
  input  logic              irq_pin_n_i,
  input  logic              xirq_pin_n_i,
  input  logic              irq_en_i,
  input  logic              xirq_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [PORT_W-1:0] pin_oe_o,
  output logic [PORT_W-1:0] pin_pu_o,
  output logic [PORT_W-1:0] pin_fsel_o,
  output logic              irq_req_o,
  output logic              xirq_req_o
);
  mode_t             mode;
  logic              run;
  altctl_t           ctl;
  logic [PORT_W-1:0] dir;

  bpc_mode_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_ab_i (mode_ab_i),
    .mode_o    (mode),
    .run_o     (run)
  );

  bpc_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run),
    .mode_i      (mode),
    .boot_user_i (mode_c_i),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wr_data_i   (wr_data_i),
    .rd_data_o   (rd_data_o),
    .ctl_o       (ctl),
    .dir_o       (dir)
  );

  bpc_pin_ctrl u_pins (
    .run_i        (run),
    .ctl_i        (ctl),
    .dir_i        (dir),
    .irq_pin_n_i  (irq_pin_n_i),
    .xirq_pin_n_i (xirq_pin_n_i),
    .irq_en_i     (irq_en_i),
    .xirq_en_i    (xirq_en_i),
    .oe_o         (pin_oe_o),
    .pu_o         (pin_pu_o),
    .fsel_o       (pin_fsel_o),
    .irq_req_o    (irq_req_o),
    .xirq_req_o   (xirq_req_o)
  );
endmodule

// File: rtl/boot_port_cfg_chk.sv
module boot_port_cfg_chk
  import bpc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input mode_t             mode,
  input logic [PORT_W-1:0] pin_oe_o,
  input logic [PORT_W-1:0] pin_pu_o,
  input logic [PORT_W-1:0] pin_fsel_o,
  input logic              irq_en_i,
  input logic              xirq_en_i,
  input logic              irq_req_o,
  input logic              xirq_req_o
);
  // R2: mode-select pins float while reset is held
  a_r2_msel_float: assert property (@(posedge clk)
    !rst_n |-> (!pin_oe_o[PIN_MSEL0] && !pin_oe_o[PIN_MSEL1] &&
                !pin_pu_o[PIN_MSEL0] && !pin_pu_o[PIN_MSEL1] && pin_fsel_o == '0));

  // R3: interrupt pins stay pulled-up inputs
  a_r3_irq_pins_input: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe_o[1:0] == 2'b00 && pin_pu_o[1:0] == 2'b11));

  // R1: captured mode never changes while running
  a_r1_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(mode));

  // R4: no request without the processor enable
  a_r4_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en_i |-> !irq_req_o) and (!xirq_en_i |-> !xirq_req_o));

  // R8: a driven pin never has its pull-up on
  a_r8_pu_off_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe_o & pin_pu_o) == '0);

  // R5: single-chip mode hands no pin to an alternate function
  a_r5_single_no_alt: assert property (@(posedge clk) disable iff (!rst_n)
    (run && is_single(mode)) |-> pin_fsel_o == '0);

  // R6: alternate-function pins are always driven
  a_r6_alt_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_fsel_o & ~pin_oe_o) == '0);
endmodule

bind boot_port_cfg boot_port_cfg_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .mode       (mode),
  .pin_oe_o   (pin_oe_o),
  .pin_pu_o   (pin_pu_o),
  .pin_fsel_o (pin_fsel_o),
  .irq_en_i   (irq_en_i),
  .xirq_en_i  (xirq_en_i),
  .irq_req_o  (irq_req_o),
  .xirq_req_o (xirq_req_o)
);

// File: tb/sim_boot_port_cfg.sv
module sim_boot_port_cfg;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_c;
  logic [1:0] mode_ab;
  logic       irq_pin_n, xirq_pin_n, irq_en, xirq_en;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data, oe, pu, fsel;
  logic       irq_req, xirq_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  boot_port_cfg u0 (
    .clk(clk), .rst_n(rst_n), .mode_c_i(mode_c), .mode_ab_i(mode_ab),
    .irq_pin_n_i(irq_pin_n), .xirq_pin_n_i(xirq_pin_n),
    .irq_en_i(irq_en), .xirq_en_i(xirq_en),
    .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .pin_oe_o(oe), .pin_pu_o(pu), .pin_fsel_o(fsel),
    .irq_req_o(irq_req), .xirq_req_o(xirq_req)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] model_alt(input logic [1:0] m, input logic [2:0] c);
    logic [7:0] a;
    a = 8'h00;
    if (m != 2'b00) a = ({8{c[0]}} & 8'hE0) | ({7'b0, c[1]} << 3) | ({7'b0, c[2]} << 2);
    return a;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic chk_pins(input string req, input logic [1:0] m, input logic [2:0] c, input logic [7:0] d);
    logic [7:0] a, o;
    a = model_alt(m, c);
    o = a | (d & 8'hFC);
    @(negedge clk);
    chk({req, " oe"}, oe, o);
    chk({req, " pu"}, pu, ~o);
    chk({req, " fsel"}, fsel, a);
  endtask

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; mode_c = 1'b0; mode_ab = 2'b00;
    irq_pin_n = 1'b1; xirq_pin_n = 1'b1; irq_en = 1'b0; xirq_en = 1'b0;
    wr_en = 1'b0; addr = 2'd0; wr_data = 8'h00;
    for (int m = 0; m < 8; m++) begin
      @(negedge clk);
      rst_n = 1'b0;
      mode_c = m[2]; mode_ab = m[1:0];
      irq_pin_n = 1'b0; xirq_pin_n = 1'b0; irq_en = 1'b1; xirq_en = 1'b1;
      repeat (3) @(negedge clk);
      // R2: pin state before capture, requests inhibited (R4)
      chk("R2 reset oe", oe, 8'h00);
      chk("R2 reset pu", pu, 8'h9F);
      chk("R2 reset fsel", fsel, 8'h00);
      chk("R4 reset req", {6'b0, irq_req, xirq_req}, 8'h00);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      mode_ab = ~m[1:0];  // R1: later changes must not matter
      irq_en = 1'b0; xirq_en = 1'b0; irq_pin_n = 1'b1; xirq_pin_n = 1'b1;
      rd(2'd1, v); chk("R7 stretch after reset", v, {7'b0, m[2]});
      rd(2'd0, v); chk("R9 ctrl after reset", v, 8'h00);
      chk_pins("R9 default pins", m[1:0], 3'b000, 8'h00);
      for (int c = 0; c < 8; c++) begin
        wr(2'd0, 8'hF8 | 8'(c));
        rd(2'd0, v);
        chk((m[1:0] == 2'b00) ? "R5 ctrl readback" : "R6 R1 ctrl readback", v,
            (m[1:0] == 2'b00) ? 8'h00 : 8'(c));
        chk_pins((m[1:0] == 2'b00) ? "R5 pins" : "R6 pins", m[1:0], 3'(c), 8'h00);
      end
      for (int k = 0; k < 4; k++) begin
        logic [7:0] d;
        d = (k == 0) ? 8'hFF : (k == 1) ? 8'hA5 : (k == 2) ? 8'h5A : 8'h00;
        wr(2'd2, d);
        rd(2'd2, v); chk("R3 dir readback", v, d & 8'hFC);
        chk_pins("R8 R3 dir pins", m[1:0], 3'b111, d);
      end
      wr(2'd1, 8'hFE); rd(2'd1, v); chk("R7 stretch write 0", v, 8'h00);
      wr(2'd1, 8'h01); rd(2'd1, v); chk("R7 stretch write 1", v, 8'h01);
      wr(2'd3, 8'hFF); rd(2'd3, v); chk("R10 addr3 read", v, 8'h00);
      chk_pins("R10 addr3 write no effect", m[1:0], 3'b111, 8'h00);
      for (int p = 0; p < 16; p++) begin
        @(negedge clk);
        irq_en = p[0]; irq_pin_n = p[1]; xirq_en = p[2]; xirq_pin_n = p[3];
        #1;
        chk("R4 irq", {7'b0, irq_req}, {7'b0, p[0] & ~p[1]});
        chk("R4 xirq", {7'b0, xirq_req}, {7'b0, p[2] & ~p[3]});
      end
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule